// File: doc/BRIEF.md
# Software Trap Exception Controller

This block does the context switch when a CPU executes a software trap. The pipeline pulses a trap strobe and supplies a 5-bit vector operand and the address to return to. On the next clock edge the controller saves the return address and the status word it holds into two save registers. It also writes a cause code into the low half of a cause register, sets the exception-pending and interrupt-disable flags in the status word, and issues a one-cycle redirect that steers fetch to one of two fixed handler entry points.

A trap is never blocked: flags already set from an earlier trap do not mask it. A return strobe reverses the switch in one cycle. It restores the status word from its save register and redirects fetch to the saved return address. The pipeline writes the status word through a plain write port. Other exception sources write the upper half of the cause register through their own port. Decode, pipeline control and interrupt arbitration stay outside the block.

Top module: `trap_exc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `eipc_q`, `eipsw_q` and `ecr_q` become 0. `psw_q` becomes 0x00000020, which has the interrupt-disable flag (bit 5) at 1 and the exception-pending flag (bit 6) at 0. `redir_valid` becomes 0.
- R2: One edge after `trap_req` is sampled high, `eipc_q` holds the `ret_pc` value sampled with it.
- R3: One edge after a trap, `eipsw_q` holds the value `psw_q` had in the cycle of the strobe.
- R4: One edge after a trap, `ecr_q[15:0]` equals 0x0040 plus the vector. `ecr_q[31:16]` changes only when `ecr_hi_we` is high, which loads `ecr_hi_wd`, and this holds even during a trap.
- R5: One edge after a trap, `psw_q` equals the old status word with bit 6 (exception-pending) and bit 5 (interrupt-disable) set to 1. All other bits are unchanged.
- R6: One edge after a trap, `redir_valid` is 1 for one cycle. `redir_pc` is then 0x00000040 for vectors 0x00 to 0x0F and 0x00000050 for vectors 0x10 to 0x1F. With no trap or return strobe, `redir_valid` is 0 in the following cycle.
- R7: A trap is taken even when bits 5 and 6 of `psw_q` are already 1, including a trap in the cycle right after another trap.
- R8: One edge after `eret_req` (with no trap), `psw_q` equals `eipsw_q`, `redir_pc` equals `eipc_q`, and `redir_valid` is 1. `eipc_q`, `eipsw_q` and `ecr_q[15:0]` keep their values.
- R9: When `trap_req` and `eret_req` are both high in one cycle, the block does only the trap and ignores the return.
- R10: When `psw_we` is high and neither strobe is high, `psw_q` loads `psw_wd` at the edge. A trap or return in the same cycle takes precedence and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap strobe, one per trap |
| trap_vec | input | 5 | Trap vector operand |
| ret_pc | input | 32 | Address to resume at after the handler |
| eret_req | input | 1 | Return-from-exception strobe |
| psw_we | input | 1 | Ordinary status word write enable |
| psw_wd | input | 32 | Ordinary status word write data |
| ecr_hi_we | input | 1 | Write enable for cause register upper half |
| ecr_hi_wd | input | 16 | Data for cause register upper half |
| psw_q | output | 32 | Current status word |
| eipc_q | output | 32 | Saved return address |
| eipsw_q | output | 32 | Saved status word |
| ecr_q | output | 32 | Cause register |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_pc | output | 32 | Redirect target address |

## Verification
A trap can land in the same cycle as a return strobe, an ordinary status write, or a write to the upper half of the cause register. The bench drives each pairing on purpose, and then keeps them colliding often in a long run of random strobes. A behavioural model in the bench applies the priority rules at every edge and compares every output on each clock. A mismatch after a cycle where both strobes were high is reported against the trap-wins rule. A mismatch after a collision with a status write is reported against the write-priority rule.

// File: rtl/trap_pkg.sv
// Shared constants and types of the software trap controller.
// Assumes a 32-bit machine word and a 5-bit trap operand.
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int VEC_W  = 5;
    localparam int HALF_W = XLEN / 2;

    // Action chosen for the coming edge, in priority order.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TRAP  = 2'd1,
        ACT_ERET  = 2'd2,
        ACT_WRITE = 2'd3
    } trap_act_e;
endpackage

// File: rtl/trap_vector_decode.sv
// Combinational decode of the trap operand into a handler entry address
// and a cause code. The top bit of the operand selects one of two entry
// addresses. The code is a fixed base plus the operand.
// Assumes VEC_W is at most CODE_W.
module trap_vector_decode #(
    parameter int          VEC_W     = 5,
    parameter int          ADDR_W    = 32,
    parameter int          CODE_W    = 16,
    parameter logic [31:0] HND_LO    = 32'h0000_0040,
    parameter logic [31:0] HND_HI    = 32'h0000_0050,
    parameter logic [15:0] CODE_BASE = 16'h0040
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] handler,
    output logic [CODE_W-1:0] code
);
    localparam int PAD_W = CODE_W - VEC_W;

    // Pick the entry address from the operand's upper bit.
    always_comb begin
        handler = vec[VEC_W-1] ? HND_HI[ADDR_W-1:0] : HND_LO[ADDR_W-1:0];
    end

    // Form a distinct cause code for each operand value.
    always_comb begin
        code = CODE_BASE[CODE_W-1:0] + {{PAD_W{1'b0}}, vec};
    end
endmodule

// File: rtl/trap_ctx_save.sv
// Exception save registers: return address, saved status word, and the
// cause register. A trap captures the first two and the cause low half.
// The cause high half is written only through its own port.
// Assumes a synchronous active-low reset.
module trap_ctx_save #(
    parameter int XLEN   = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_trap,
    input  logic [XLEN-1:0]   ret_pc,
    input  logic [XLEN-1:0]   psw_cur,
    input  logic [HALF_W-1:0] code,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] hi_wd,
    output logic [XLEN-1:0]   eipc_q,
    output logic [XLEN-1:0]   eipsw_q,
    output logic [XLEN-1:0]   ecr_q
);
    logic [HALF_W-1:0] ecr_lo, ecr_hi;

    // Capture the return address and status word on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eipc_q  <= '0;
            eipsw_q <= '0;
        end else if (take_trap) begin
            eipc_q  <= ret_pc;
            eipsw_q <= psw_cur;
        end
    end

    // Write the cause code into the low half on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n)         ecr_lo <= '0;
        else if (take_trap) ecr_lo <= code;
    end

    // Load the high half from its own write port only.
    always_ff @(posedge clk) begin
        if (!rst_n)     ecr_hi <= '0;
        else if (hi_we) ecr_hi <= hi_wd;
    end

    assign ecr_q = {ecr_hi, ecr_lo};

    a_r2_eipc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> eipc_q == $past(ret_pc));
    a_r3_eipsw_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> eipsw_q == $past(psw_cur));
    a_r4_hi_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> ecr_q[XLEN-1:HALF_W] == $past(ecr_q[XLEN-1:HALF_W]));
    a_r8_saves_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |=> eipc_q == $past(eipc_q) && eipsw_q == $past(eipsw_q));
endmodule

// File: rtl/trap_status_reg.sv
// Status word register. Priority for the edge: trap (set both flags),
// then return (restore the saved word), then an ordinary write.
// Assumes the action has already been resolved by the top.
module trap_status_reg
    import trap_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          EP_BIT  = 6,
    parameter int          ID_BIT  = 5,
    parameter logic [31:0] PSW_RST = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trap_act_e       act,
    input  logic [XLEN-1:0] eipsw,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] psw_q
);
    localparam logic [XLEN-1:0] FLAG_MASK =
        (XLEN'(1) << EP_BIT) | (XLEN'(1) << ID_BIT);

    logic [XLEN-1:0] psw_nxt;

    // Select the next status word from the resolved action.
    always_comb begin
        unique case (act)
            ACT_TRAP:  psw_nxt = psw_q | FLAG_MASK;
            ACT_ERET:  psw_nxt = eipsw;
            ACT_WRITE: psw_nxt = wd;
            default:   psw_nxt = psw_q;
        endcase
    end

    // Hold the status word, reset with interrupts disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) psw_q <= PSW_RST[XLEN-1:0];
        else        psw_q <= psw_nxt;
    end

    a_r5_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |=> psw_q[EP_BIT] && psw_q[ID_BIT]);
    a_r5_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |=> (psw_q & ~FLAG_MASK) == ($past(psw_q) & ~FLAG_MASK));
    a_r8_psw_restore: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ERET |=> psw_q == $past(eipsw));
endmodule

// File: rtl/trap_redirect.sv
// Fetch redirect register: a one-cycle valid pulse with the target,
// the handler entry on a trap or the saved address on a return.
// Assumes the action has already been resolved by the top.
module trap_redirect
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trap_act_e       act,
    input  logic [XLEN-1:0] handler,
    input  logic [XLEN-1:0] eipc,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc
);
    // Register the pulse and its target for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            redir_valid <= (act == ACT_TRAP) || (act == ACT_ERET);
            if (act == ACT_TRAP)      redir_pc <= handler;
            else if (act == ACT_ERET) redir_pc <= eipc;
        end
    end

    a_r6_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE || act == ACT_WRITE) |=> !redir_valid);
    a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ERET |=> redir_valid && redir_pc == $past(eipc));
endmodule

// File: rtl/trap_exc_ctrl.sv
// Top of the software trap controller. Resolves the priority of the
// strobes for each edge (trap, then return, then status write). Combines
// the vector decoder, the save registers, the status register and the
// redirect register. Assumes strobes are synchronous to clk.
module trap_exc_ctrl
    import trap_pkg::*;
#(
    parameter int          EP_BIT    = 6,
    parameter int          ID_BIT    = 5,
    parameter logic [31:0] PSW_RST   = 32'h0000_0020,
    parameter logic [31:0] HND_LO    = 32'h0000_0040,
    parameter logic [31:0] HND_HI    = 32'h0000_0050,
    parameter logic [15:0] CODE_BASE = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [XLEN-1:0]   ret_pc,
    input  logic              eret_req,
    input  logic              psw_we,
    input  logic [XLEN-1:0]   psw_wd,
    input  logic              ecr_hi_we,
    input  logic [HALF_W-1:0] ecr_hi_wd,
    output logic [XLEN-1:0]   psw_q,
    output logic [XLEN-1:0]   eipc_q,
    output logic [XLEN-1:0]   eipsw_q,
    output logic [XLEN-1:0]   ecr_q,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc
);
    trap_act_e          act;
    logic [XLEN-1:0]    handler;
    logic [HALF_W-1:0]  code;

    // Resolve strobe priority: trap, then return, then write.
    always_comb begin
        if (trap_req)      act = ACT_TRAP;
        else if (eret_req) act = ACT_ERET;
        else if (psw_we)   act = ACT_WRITE;
        else               act = ACT_NONE;
    end

    trap_vector_decode #(
        .VEC_W(VEC_W), .ADDR_W(XLEN), .CODE_W(HALF_W),
        .HND_LO(HND_LO), .HND_HI(HND_HI), .CODE_BASE(CODE_BASE)
    ) u_dec (
        .vec(trap_vec), .handler(handler), .code(code)
    );

    trap_ctx_save #(.XLEN(XLEN), .HALF_W(HALF_W)) u_save (
        .clk(clk), .rst_n(rst_n), .take_trap(act == ACT_TRAP),
        .ret_pc(ret_pc), .psw_cur(psw_q), .code(code),
        .hi_we(ecr_hi_we), .hi_wd(ecr_hi_wd),
        .eipc_q(eipc_q), .eipsw_q(eipsw_q), .ecr_q(ecr_q)
    );

    trap_status_reg #(
        .XLEN(XLEN), .EP_BIT(EP_BIT), .ID_BIT(ID_BIT), .PSW_RST(PSW_RST)
    ) u_psw (
        .clk(clk), .rst_n(rst_n), .act(act), .eipsw(eipsw_q),
        .wd(psw_wd), .psw_q(psw_q)
    );

    trap_redirect #(.XLEN(XLEN)) u_redir (
        .clk(clk), .rst_n(rst_n), .act(act), .handler(handler),
        .eipc(eipc_q), .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    a_r6_handler_pick: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> redir_valid &&
            redir_pc == ($past(trap_vec[VEC_W-1]) ? HND_HI : HND_LO));
    a_r4_code_value: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ecr_q[HALF_W-1:0] ==
            CODE_BASE + {{(HALF_W-VEC_W){1'b0}}, $past(trap_vec)});
    a_r9_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && eret_req) |=> psw_q[EP_BIT] && eipc_q == $past(ret_pc));
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> psw_q == PSW_RST && ecr_q == '0 && !redir_valid);
endmodule

// File: tb/trap_exc_ctrl_test.sv
// Bench: behavioural reference model, compared on every clock.
module trap_exc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0, eret_req = 1'b0, psw_we = 1'b0, ecr_hi_we = 1'b0;
    logic [4:0]  trap_vec = '0;
    logic [31:0] ret_pc = '0, psw_wd = '0;
    logic [15:0] ecr_hi_wd = '0;
    logic [31:0] psw_q, eipc_q, eipsw_q, ecr_q, redir_pc;
    logic        redir_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Model state
    logic [31:0] m_psw, m_eipc, m_eipsw, m_ecr, m_rpc;
    logic        m_rv;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    trap_exc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
        .ret_pc(ret_pc), .eret_req(eret_req), .psw_we(psw_we), .psw_wd(psw_wd),
        .ecr_hi_we(ecr_hi_we), .ecr_hi_wd(ecr_hi_wd),
        .psw_q(psw_q), .eipc_q(eipc_q), .eipsw_q(eipsw_q), .ecr_q(ecr_q),
        .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_psw = 32'h20; m_eipc = 0; m_eipsw = 0; m_ecr = 0;
            m_rv = 0; m_rpc = 0; m_tag = "R1";
        end else begin
            if (trap_req && eret_req)                  m_tag = "R9";
            else if (trap_req && m_psw[6] && m_psw[5]) m_tag = "R7";
            else if (trap_req && (psw_we || ecr_hi_we)) m_tag = "R10";
            else if (trap_req)                         m_tag = "R5";
            else if (eret_req)                         m_tag = "R8";
            else if (psw_we)                           m_tag = "R10";
            else                                       m_tag = "R6";
            if (ecr_hi_we) m_ecr[31:16] = ecr_hi_wd;
            if (trap_req) begin
                m_eipc  = ret_pc;
                m_eipsw = m_psw;
                m_ecr[15:0] = 16'h0040 + 16'(trap_vec);
                m_psw   = m_psw | 32'h60;
                m_rpc   = trap_vec[4] ? 32'h50 : 32'h40;
                m_rv    = 1;
            end else if (eret_req) begin
                m_psw = m_eipsw;
                m_rpc = m_eipc;
                m_rv  = 1;
            end else begin
                if (psw_we) m_psw = psw_wd;
                m_rv = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(m_tag == "R6" || m_tag == "R5" ? "R5" : m_tag, "psw", psw_q, m_psw);
        chk(m_tag == "R8" ? "R8" : "R2", "eipc", eipc_q, m_eipc);
        chk(m_tag == "R8" ? "R8" : "R3", "eipsw", eipsw_q, m_eipsw);
        chk("R4", "ecr", ecr_q, m_ecr);
        chk(m_tag == "R9" ? "R9" : "R6", "redir_valid", 32'(redir_valid), 32'(m_rv));
        if (m_rv) chk(m_tag == "R8" ? "R8" : "R6", "redir_pc", redir_pc, m_rpc);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One cycle: drive at negedge, compare at next negedge.
    task automatic step(input logic t, input logic [4:0] v, input logic [31:0] rp,
                        input logic e, input logic w, input logic [31:0] wd,
                        input logic hw, input logic [15:0] hd);
        trap_req = t; trap_vec = v; ret_pc = rp; eret_req = e;
        psw_we = w; psw_wd = wd; ecr_hi_we = hw; ecr_hi_wd = hd;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "psw reset", psw_q, 32'h20);
        chk("R1", "eipc reset", eipc_q, 0);
        chk("R1", "eipsw reset", eipsw_q, 0);
        chk("R1", "ecr reset", ecr_q, 0);
        chk("R1", "redir reset", 32'(redir_valid), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 32'h0000_0001, 0, 0);           // R10 write
        step(1, 5'h00, 32'h1000, 0, 0, 0, 0, 0);            // R6 low vector
        chk("R6", "handler lo", redir_pc, 32'h40);
        chk("R4", "code 0x40", 32'(ecr_q[15:0]), 32'h40);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6", "pulse ends", 32'(redir_valid), 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);                       // R8 return
        chk("R8", "ret target", redir_pc, 32'h1000);
        chk("R8", "psw restored", psw_q, 32'h1);
        step(1, 5'h0F, 32'h2000, 0, 0, 0, 0, 0);
        step(1, 5'h10, 32'h3000, 0, 0, 0, 0, 0);            // R7 back to back
        chk("R7", "second trap taken", eipc_q, 32'h3000);
        chk("R6", "handler hi", redir_pc, 32'h50);
        step(1, 5'h1F, 32'h4000, 1, 1, 32'hFFFF_0000, 1, 16'hBEEF); // R9 + R10 + R4
        chk("R9", "return ignored", eipc_q, 32'h4000);
        chk("R4", "hi half written", 32'(ecr_q[31:16]), 32'hBEEF);
        chk("R4", "code 0x5f", 32'(ecr_q[15:0]), 32'h5F);
        step(0, 0, 0, 1, 1, 32'h1234_5678, 0, 0);           // R10 dropped on return
        step(0, 0, 0, 0, 1, 32'h0000_0000, 0, 0);
        step(1, 5'h03, 32'h5000, 0, 0, 0, 0, 0);            // R5 from clear psw
        chk("R5", "flags only", psw_q, 32'h60);
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) == 0, 5'($urandom), $urandom,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom,
                 $urandom_range(0, 4) == 0, 16'($urandom));
        end
        finish_run();
    end

    // Watchdog
    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        finish_run();
    end
endmodule